// File: doc/BRIEF.md
# Row Repair Address Remapper

This block sits between a memory's row address and its row decoder. It holds a small repair register in which each entry names one faulty row. An access to a named row goes to a spare row placed just above the last regular row. Accesses to every other row pass through unchanged. The remap is a combinational compare against the registered entries, so a repaired row is redirected in the same cycle it is presented.

The repair register can be filled in one of two ways, chosen by a mode pin that stays fixed from reset onward:

- **Diagnostic mode.** A test engine reports faulty rows one at a time. Entries are taken in index order, repeated reports of a row are absorbed, and a report that finds no free spare raises a sticky overflow flag.
- **Fuse mode.** At power-up, a stored fuse image is shifted in serially while a load enable is high. Remapping takes effect as soon as the shift ends, with no diagnostic pass.

In either mode, the whole register can be rotated out on a scan pin. The bits come out in the same order the fuse load takes them in, so a captured image can be programmed into fuses and replayed later. A ready flag marks the end of the power-up phase.

Top module: `row_repair_remap`

## Requirements
- R1: After a synchronous reset, every entry is invalid, ready and overflow are low, and row_out equals row_in zero-extended to ROW_W+1 bits.
- R2: In diagnostic mode before ready, a report (fault_valid high at a clock edge) of a new row fills the lowest-numbered free entry. From the next cycle on, that row maps to 2^ROW_W + entry index, and spare_hit is high for it.
- R3: A report of a row already held by a valid entry changes no entry and leaves the remaining spares free.
- R4: A report of a new row while all entries are valid sets overflow and leaves every entry unchanged. Overflow stays high until reset.
- R5: In diagnostic mode, a diag_done pulse makes ready high from the next cycle. After that, fault reports have no effect on the mapping.
- R6: In fuse mode before ready, each clock with fuse_en high shifts fuse_bit into the top of the image and moves the image down one bit. In the image, entry k occupies bits k*(ROW_W+1) up to k*(ROW_W+1)+ROW_W: the row address sits in the low ROW_W bits and the valid flag in the top bit. Ready rises one cycle after fuse_en first goes low following a load, and the loaded repairs are active at once.
- R7: Fault reports have no effect in fuse mode. fuse_en has no effect in diagnostic mode or once ready is high.
- R8: scan_out always shows image bit 0. Each clock with scan_en high, when no fuse shift is taking place, rotates the image down by one bit. After ROW_W+1 times SPARES rotations, the register and the mapping are back to what they were.
- R9: When more than one valid entry holds the incoming row, the lowest entry index decides the spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fuse | input | 1 | 1 = fill from fuse image, 0 = fill from diagnostic reports |
| row_in | input | ROW_W | Logical row address |
| row_out | output | ROW_W+1 | Physical row sent to the decoder |
| spare_hit | output | 1 | Current access is redirected to a spare |
| fault_valid | input | 1 | Diagnostic fault report strobe |
| fault_row | input | ROW_W | Row address of the reported fault |
| diag_done | input | 1 | Diagnostic pass finished |
| fuse_en | input | 1 | Fuse image shift enable |
| fuse_bit | input | 1 | Serial fuse image data |
| scan_en | input | 1 | Rotate repair register toward scan_out |
| scan_out | output | 1 | Bit 0 of the repair register |
| ready | output | 1 | Power-up repair phase finished |
| overflow | output | 1 | Sticky: a fault found no free spare |

## Verification
The bench builds the block with ROW_W = 6 and SPARES = 4. This makes the full space 64 rows and the fuse image 28 bits. Every row can be swept after each change to the repair register, so every mapped and unmapped row is compared with the bench model. Reports are drawn from a small pool, so repeats and overflow happen often in random rounds. Fuse images carry random valid bits and, in one round, a forced shared row so the lowest-index rule is exercised.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_FUSE  = 2'd1,
        PH_READY = 2'd2
    } rr_phase_e;

    function automatic int unsigned rr_entry_w(input int unsigned row_w);
        return row_w + 1;
    endfunction

    function automatic int unsigned rr_idx_w(input int unsigned spares);
        return (spares > 1) ? $clog2(spares) : 1;
    endfunction

endpackage

// File: rtl/rr_match.sv
`timescale 1ns/1ps
module rr_match #(
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned SPARES = 4,
    localparam int unsigned EW    = rr_pkg::rr_entry_w(ROW_W),
    localparam int unsigned IMG_W = EW * SPARES,
    localparam int unsigned IDX_W = rr_pkg::rr_idx_w(SPARES)
) (
    input  logic [IMG_W-1:0] img,
    input  logic [ROW_W-1:0] row,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [SPARES-1:0] eq;

    for (genvar k = 0; k < SPARES; k++) begin : g_cmp
        assign eq[k] = img[k*EW + ROW_W] && (img[k*EW +: ROW_W] == row);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = SPARES - 1; k >= 0; k--) begin
            if (eq[k]) begin
                hit = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/rr_entry_store.sv
`timescale 1ns/1ps
module rr_entry_store #(
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned SPARES = 4,
    localparam int unsigned EW    = rr_pkg::rr_entry_w(ROW_W),
    localparam int unsigned IMG_W = EW * SPARES,
    localparam int unsigned IDX_W = rr_pkg::rr_idx_w(SPARES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_shift,
    input  logic             load_bit,
    input  logic             scan_rot,
    input  logic             alloc_en,
    input  logic [ROW_W-1:0] alloc_row,
    output logic [IMG_W-1:0] img,
    output logic             full,
    output logic [IDX_W-1:0] free_idx
);

    logic [SPARES-1:0] vld;

    for (genvar k = 0; k < SPARES; k++) begin : g_vld
        assign vld[k] = img[k*EW + ROW_W];
    end

    assign full = &vld;

    always_comb begin
        free_idx = '0;
        for (int k = SPARES - 1; k >= 0; k--) begin
            if (!vld[k]) free_idx = IDX_W'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            img <= '0;
        end else if (load_shift) begin
            img <= {load_bit, img[IMG_W-1:1]};
        end else if (scan_rot) begin
            img <= {img[0], img[IMG_W-1:1]};
        end else if (alloc_en) begin
            img[free_idx*EW +: EW] <= {1'b1, alloc_row};
        end
    end

    AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && !load_shift && !scan_rot) |=>
            (img[$past(free_idx)*EW + ROW_W] && img[$past(free_idx)*EW +: ROW_W] == $past(alloc_row))); // R2

    AST_ALLOC_LOWEST: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !vld[free_idx]); // R2

endmodule

// File: rtl/rr_ctrl.sv
`timescale 1ns/1ps
module rr_ctrl
    import rr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_fuse,
    input  logic fault_valid,
    input  logic diag_done,
    input  logic fuse_en,
    input  logic dup,
    input  logic full,
    output logic accept,
    output logic alloc_en,
    output logic load_shift,
    output logic ready,
    output logic overflow
);

    rr_phase_e phase_q, phase_d;

    assign ready      = (phase_q == PH_READY);
    assign load_shift = mode_fuse && fuse_en && !ready;
    assign accept     = !mode_fuse && fault_valid && !ready;
    assign alloc_en   = accept && !dup && !full;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_WAIT: begin
                if (mode_fuse && fuse_en)        phase_d = PH_FUSE;
                else if (!mode_fuse && diag_done) phase_d = PH_READY;
            end
            PH_FUSE: begin
                if (!fuse_en) phase_d = PH_READY;
            end
            default: phase_d = PH_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_WAIT;
            overflow <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept && !dup && full) overflow <= 1'b1;
        end
    end

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R4

    AST_NO_ALLOC_FUSE: assert property (@(posedge clk) disable iff (rst)
        mode_fuse |-> !alloc_en); // R7

endmodule

// File: rtl/row_repair_remap.sv
`timescale 1ns/1ps
module row_repair_remap #(
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned SPARES = 4,
    localparam int unsigned PHYS_W = ROW_W + 1,
    localparam int unsigned EW     = rr_pkg::rr_entry_w(ROW_W),
    localparam int unsigned IMG_W  = EW * SPARES,
    localparam int unsigned IDX_W  = rr_pkg::rr_idx_w(SPARES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_fuse,
    input  logic [ROW_W-1:0]  row_in,
    output logic [PHYS_W-1:0] row_out,
    output logic              spare_hit,
    input  logic              fault_valid,
    input  logic [ROW_W-1:0]  fault_row,
    input  logic              diag_done,
    input  logic              fuse_en,
    input  logic              fuse_bit,
    input  logic              scan_en,
    output logic              scan_out,
    output logic              ready,
    output logic              overflow
);

    logic [IMG_W-1:0] img;
    logic             full, dup, accept, alloc_en, load_shift;
    logic [IDX_W-1:0] free_idx, hit_idx, dup_idx;

    rr_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_fuse   (mode_fuse),
        .fault_valid (fault_valid),
        .diag_done   (diag_done),
        .fuse_en     (fuse_en),
        .dup         (dup),
        .full        (full),
        .accept      (accept),
        .alloc_en    (alloc_en),
        .load_shift  (load_shift),
        .ready       (ready),
        .overflow    (overflow)
    );

    rr_entry_store #(.ROW_W(ROW_W), .SPARES(SPARES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_shift (load_shift),
        .load_bit   (fuse_bit),
        .scan_rot   (scan_en && !load_shift),
        .alloc_en   (alloc_en),
        .alloc_row  (fault_row),
        .img        (img),
        .full       (full),
        .free_idx   (free_idx)
    );

    rr_match #(.ROW_W(ROW_W), .SPARES(SPARES)) u_map (
        .img (img),
        .row (row_in),
        .hit (spare_hit),
        .idx (hit_idx)
    );

    rr_match #(.ROW_W(ROW_W), .SPARES(SPARES)) u_dup (
        .img (img),
        .row (fault_row),
        .hit (dup),
        .idx (dup_idx)
    );

    assign scan_out = img[0];
    assign row_out  = spare_hit ? ((PHYS_W'(1) << ROW_W) | PHYS_W'(hit_idx))
                                : PHYS_W'(row_in);

    AST_DUP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (accept && dup && !scan_en) |=> $stable(img)); // R3

    AST_DUP_SEEN: assert property (@(posedge clk) disable iff (rst)
        (accept && dup) |-> (img[dup_idx*EW + ROW_W] && img[dup_idx*EW +: ROW_W] == fault_row)); // R3

    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (accept && !dup && full && !scan_en) |=> ($stable(img) && overflow)); // R4

    AST_SPARE_RANGE: assert property (@(posedge clk) disable iff (rst)
        spare_hit |-> (row_out[ROW_W] && row_out[ROW_W-1:0] < (ROW_W)'(SPARES))); // R2

endmodule

// File: tb/row_repair_remap_tb_top.sv
`timescale 1ns/1ps
module row_repair_remap_tb_top;

    localparam int RW  = 6;
    localparam int NS  = 4;
    localparam int EW  = RW + 1;
    localparam int IMG = EW * NS;
    localparam int NROWS = 1 << RW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_fuse = 1'b0;
    logic [RW-1:0] row_in = '0;
    logic [RW:0]   row_out;
    logic          spare_hit;
    logic          fault_valid = 1'b0;
    logic [RW-1:0] fault_row = '0;
    logic          diag_done = 1'b0;
    logic          fuse_en = 1'b0;
    logic          fuse_bit = 1'b0;
    logic          scan_en = 1'b0;
    logic          scan_out;
    logic          ready;
    logic          overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit          m_vld [NS];
    logic [RW-1:0] m_row [NS];
    bit          m_ovf;

    always #2 clk = ~clk;

    row_repair_remap #(.ROW_W(RW), .SPARES(NS)) dut_i (
        .clk(clk), .rst(rst), .mode_fuse(mode_fuse), .row_in(row_in),
        .row_out(row_out), .spare_hit(spare_hit), .fault_valid(fault_valid),
        .fault_row(fault_row), .diag_done(diag_done), .fuse_en(fuse_en),
        .fuse_bit(fuse_bit), .scan_en(scan_en), .scan_out(scan_out),
        .ready(ready), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_map(input int r);
        for (int k = 0; k < NS; k++)
            if (m_vld[k] && m_row[k] == r[RW-1:0]) return NROWS + k;
        return r;
    endfunction

    function automatic void model_report(input logic [RW-1:0] r);
        for (int k = 0; k < NS; k++)
            if (m_vld[k] && m_row[k] == r) return;
        for (int k = 0; k < NS; k++)
            if (!m_vld[k]) begin
                m_vld[k] = 1'b1;
                m_row[k] = r;
                return;
            end
        m_ovf = 1'b1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(input string req);
        for (int r = 0; r < NROWS; r++) begin
            row_in = r[RW-1:0];
            #0.1;
            chk(req, int'(row_out), exp_map(r));
            chk(req, int'(spare_hit), int'(exp_map(r) >= NROWS));
        end
    endtask

    task automatic do_reset(input bit fuse);
        rst = 1'b1;
        mode_fuse = fuse;
        fault_valid = 1'b0; diag_done = 1'b0; fuse_en = 1'b0; scan_en = 1'b0;
        for (int k = 0; k < NS; k++) begin m_vld[k] = 1'b0; m_row[k] = '0; end
        m_ovf = 1'b0;
        step(); step();
        rst = 1'b0;
        chk("R1 ready", int'(ready), 0);
        chk("R1 overflow", int'(overflow), 0);
    endtask

    task automatic report(input logic [RW-1:0] r, input bit effective);
        fault_valid = 1'b1;
        fault_row = r;
        step();
        fault_valid = 1'b0;
        if (effective) model_report(r);
        chk("R4 overflow flag", int'(overflow), int'(m_ovf));
    endtask

    task automatic fuse_load(input logic [IMG-1:0] img);
        fuse_en = 1'b1;
        for (int i = 0; i < IMG; i++) begin
            fuse_bit = img[i];
            step();
            chk("R6 ready low during load", int'(ready), 0);
        end
        fuse_en = 1'b0;
        fuse_bit = 1'b0;
        for (int k = 0; k < NS; k++) begin
            m_vld[k] = img[k*EW + RW];
            m_row[k] = img[k*EW +: RW];
        end
        step();
        chk("R6 ready after load", int'(ready), 1);
    endtask

    // soft-mode round
    task automatic soft_round(input int nrep);
        logic [RW-1:0] pool [6];
        do_reset(1'b0);
        sweep("R1 passthrough");
        for (int i = 0; i < 6; i++) pool[i] = RW'($urandom);
        for (int i = 0; i < nrep; i++) begin
            report(pool[$urandom % 6], 1'b1);
            row_in = RW'($urandom);
            #0.1;
            chk("R2 R3 R4 map", int'(row_out), exp_map(int'(row_in)));
        end
        sweep("R2 R3 R4 sweep");
        diag_done = 1'b1;
        step();
        diag_done = 1'b0;
        chk("R5 ready", int'(ready), 1);
        for (int i = 0; i < 3; i++) report(RW'($urandom), 1'b0);
        sweep("R5 late reports ignored");
    endtask

    initial begin
        logic [IMG-1:0] img;
        void'($urandom(32'h5eed_0042));

        // directed: fill order, duplicate, overflow
        do_reset(1'b0);
        sweep("R1 passthrough");
        report(6'd9, 1'b1);
        row_in = 6'd9; #0.1;
        chk("R2 first spare", int'(row_out), NROWS + 0);
        report(6'd20, 1'b1);
        report(6'd9, 1'b1);
        report(6'd33, 1'b1);
        row_in = 6'd33; #0.1;
        chk("R3 duplicate did not consume spare", int'(row_out), NROWS + 2);
        report(6'd47, 1'b1);
        chk("R4 no overflow at exactly full", int'(overflow), 0);
        report(6'd5, 1'b1);
        chk("R4 overflow set", int'(overflow), 1);
        row_in = 6'd5; #0.1;
        chk("R4 extra row not mapped", int'(row_out), 5);
        report(6'd20, 1'b1);
        sweep("R4 entries unchanged");
        // fuse_en ignored in diagnostic mode
        fuse_en = 1'b1; fuse_bit = 1'b1;
        step(); step(); step();
        fuse_en = 1'b0; fuse_bit = 1'b0;
        sweep("R7 fuse_en ignored in diag mode");
        chk("R7 ready not raised by fuse_en", int'(ready), 0);
        diag_done = 1'b1; step(); diag_done = 1'b0;
        chk("R5 ready", int'(ready), 1);
        chk("R4 overflow sticky", int'(overflow), 1);

        // random diagnostic rounds
        for (int rnd = 0; rnd < 4; rnd++) soft_round(3 + rnd * 2);

        // fuse rounds
        for (int rnd = 0; rnd < 4; rnd++) begin
            do_reset(1'b1);
            report(RW'($urandom), 1'b0);
            sweep("R7 report ignored in fuse mode");
            img = IMG'({$urandom, $urandom});
            if (rnd == 0) begin
                img[0*EW + RW] = 1'b0;
                img[1*EW + RW] = 1'b1;
                img[2*EW + RW] = 1'b1;
                img[2*EW +: RW] = img[1*EW +: RW];
            end
            fuse_load(img);
            sweep("R6 R9 fuse map");
            report(RW'($urandom), 1'b0);
            fuse_en = 1'b1; fuse_bit = 1'b1;
            step(); step();
            fuse_en = 1'b0; fuse_bit = 1'b0;
            sweep("R7 late fuse_en and report ignored");
            chk("R8 scan_out bit0", int'(scan_out), int'(img[0]));
            scan_en = 1'b1;
            for (int i = 0; i < IMG; i++) begin
                chk("R8 scan stream", int'(scan_out), int'(img[i]));
                step();
            end
            scan_en = 1'b0;
            sweep("R8 contents restored after scan");
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule